// File: doc/BRIEF.md
# Shared-Stream Transmit Frame Splitter

This block sits between a downstream bulk data path and four serial transmitters. The host sends one fixed-size frame that covers every port. The frame arrives one byte at a time on a valid/ready stream, and start and end markers delimit it. The frame is cut into equal slots. Each slot opens with a short header that names a destination port, carries a write token and gives a payload count. The payload bytes that follow are passed, unchanged and in order, to the byte FIFO of the named port.

Any slot whose header fails its checks is dropped as a whole and reported on a one-cycle error pulse. This happens when the token is wrong, the port number is out of range or the count is larger than the slot can hold. A frame whose end marker comes early is cut short and reported in the same way. A full destination FIFO stalls the shared input until it drains, so no byte is lost. Bytes that arrive outside a frame are accepted and thrown away.

Top module: `txframe_demux`

## Requirements
- R1: A frame is 512 accepted bytes, starting with the byte that carries `in_sof`. It is split into four consecutive 128-byte slots. In each slot, offset 0 is the destination port number, offset 1 is the token, offset 2 is the payload count and offset 3 is a spare byte whose value has no effect.
- R2: With a valid header, the slot's bytes at offsets 4 up to 4+count-1 appear on the destination port in arrival order and unchanged (`out_data` lane p, with `out_valid[p]`). No other byte of the frame is forwarded.
- R3: The destination is taken from offset 0 of the slot, whatever the slot's position in the frame. At most one port is valid in any cycle.
- R4: A slot with a count of 0 forwards nothing and raises no error.
- R5: A slot whose token is not 0x02 raises `blk_err` and forwards nothing.
- R6: A slot whose port number is 4 or greater raises `blk_err` and forwards nothing.
- R7: A count of 124 is accepted in full. A count of 125 or more raises `blk_err` and forwards nothing.
- R8: While the byte on offer is a payload byte for a port whose `fifo_full` is high, `in_ready` is low and no `out_valid` is high. The byte is delivered once the port has room.
- R9: An `in_eof` on a byte other than byte 511 ends the frame and raises `blk_err`. Payload bytes before and including the marked byte are forwarded according to their slot header. The next frame is handled normally.
- R10: Bytes accepted outside a frame are dropped. `blk_err` is a one-cycle pulse in the cycle after the offending byte is accepted: the header's last byte, or the early end byte.
- R11: During reset `in_ready` is high, no `out_valid` is high, and `blk_err` is low after the first reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_data | input | 8 | Incoming frame byte |
| in_valid | input | 1 | `in_data` holds a byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_ready | output | 1 | Byte is taken this cycle |
| fifo_full | input | 4 | Per-port FIFO has no room |
| out_data | output | 32 | Per-port byte lanes, lane p at bits 8p+7:8p |
| out_valid | output | 4 | Per-port write strobe |
| blk_err | output | 1 | Malformed slot or short frame pulse |

## Verification
The checks assume that a byte offered with `in_valid` stays on the input, with its markers, until `in_ready` takes it. They also assume that `fifo_full` changes only between clock edges. The bench driver holds each byte, its start marker and its end marker unchanged until it sees `in_ready`. The full pattern is changed only at the falling clock edge, so the stall check sees one steady value per cycle. The scoreboard queues the payload bytes that each slot header allows. It expects nothing for slots that are dropped or fall after an early end. It also expects nothing for stray bytes sent without a start marker.

// File: rtl/txdmx_pkg.sv
`timescale 1ns/1ps
// Shared constants and header layout for the transmit frame splitter.
package txdmx_pkg;
    localparam logic [7:0] WR_TOKEN = 8'h02;

    // Header fields captured from slot offsets 0, 1 and 2.
    typedef struct packed {
        logic [7:0] port;
        logic [7:0] token;
        logic [7:0] count;
    } slot_hdr_t;
endpackage

// File: rtl/txdmx_frame_pos.sv
`timescale 1ns/1ps
// Tracks the byte position inside a frame.
// Assumes: accept is a completed input handshake; a frame opens only on sof.
// A byte with eof before the last position ends the frame early (short_end).
module txdmx_frame_pos #(
    parameter int FRAME_BYTES = 512,
    parameter int POS_W       = 9,
    parameter int OFF_W       = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             sof,
    input  logic             eof,
    output logic             live,
    output logic [OFF_W-1:0] off,
    output logic             short_end
);
    logic             active;
    logic [POS_W-1:0] cnt;
    logic [POS_W-1:0] pos;
    logic             last;

    // Current byte position; a sof byte opens a frame at position 0.
    always_comb begin
        live      = active | sof;
        pos       = active ? cnt : '0;
        last      = (pos == POS_W'(FRAME_BYTES - 1));
        off       = pos[OFF_W-1:0];
        short_end = accept & live & eof & ~last;
    end

    // Advance the position or close the frame on its last or marked byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (accept && live) begin
            if (eof || last) begin
                active <= 1'b0;
                cnt    <= '0;
            end else begin
                active <= 1'b1;
                cnt    <= pos + 1'b1;
            end
        end
    end
endmodule

// File: rtl/txdmx_hdr_check.sv
`timescale 1ns/1ps
// Captures the slot header and decides whether the slot's payload is forwarded.
// Assumes: take is high only for accepted bytes inside a frame.
// The verdict is made on offset 3 and held until offset 0 of the next slot.
module txdmx_hdr_check
    import txdmx_pkg::*;
#(
    parameter int NPORT   = 4,
    parameter int MAX_PAY = 124,
    parameter int OFF_W   = 7,
    parameter int IDX_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [OFF_W-1:0] off,
    input  logic [7:0]       din,
    output logic             blk_ok,
    output logic [IDX_W-1:0] blk_port,
    output logic [7:0]       blk_len,
    output logic             hdr_bad
);
    slot_hdr_t hdr;
    logic      at_end;

    // Flag a malformed header on its final byte.
    always_comb begin
        at_end  = take && (off == OFF_W'(3));
        hdr_bad = at_end && ((hdr.token != WR_TOKEN) ||
                             (hdr.port >= 8'(NPORT)) ||
                             (hdr.count > 8'(MAX_PAY)));
    end

    // Store header bytes as they pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr <= '0;
        end else if (take) begin
            case (off)
                OFF_W'(0): hdr.port  <= din;
                OFF_W'(1): hdr.token <= din;
                OFF_W'(2): hdr.count <= din;
                default:   ;
            endcase
        end
    end

    // Hold the slot verdict, cleared at the start of every slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_ok   <= 1'b0;
            blk_port <= '0;
            blk_len  <= '0;
        end else if (take && off == OFF_W'(0)) begin
            blk_ok <= 1'b0;
        end else if (at_end) begin
            blk_ok   <= !hdr_bad && (hdr.count != 8'd0);
            blk_port <= hdr.port[IDX_W-1:0];
            blk_len  <= hdr.count;
        end
    end
endmodule

// File: rtl/txdmx_route.sv
`timescale 1ns/1ps
// Steers a payload byte to its port and stalls the input on a full FIFO.
// Assumes: blk_ok/blk_port/blk_len describe the current slot from offset 4 on.
module txdmx_route #(
    parameter int NPORT     = 4,
    parameter int OFF_W     = 7,
    parameter int IDX_W     = 2,
    parameter int HDR_BYTES = 4
) (
    input  logic             live,
    input  logic [OFF_W-1:0] off,
    input  logic             blk_ok,
    input  logic [IDX_W-1:0] blk_port,
    input  logic [7:0]       blk_len,
    input  logic             in_valid,
    input  logic [NPORT-1:0] fifo_full,
    output logic             in_ready,
    output logic [NPORT-1:0] out_valid
);
    logic [7:0] rel;
    logic       want;

    // Is the offered byte inside the counted payload of a good slot?
    always_comb begin
        rel      = 8'(off) - 8'(HDR_BYTES);
        want     = live && blk_ok && (off >= OFF_W'(HDR_BYTES)) && (rel < blk_len);
        in_ready = !(want && fifo_full[blk_port]);
    end

    // One strobe per port, raised only when that port has room.
    for (genvar p = 0; p < NPORT; p++) begin : g_lane
        assign out_valid[p] = in_valid && want && (blk_port == IDX_W'(p)) && !fifo_full[p];
    end
endmodule

// File: rtl/txframe_demux.sv
`timescale 1ns/1ps
// Splits a fixed multi-port transmit frame into per-port byte streams.
// Assumes: input bytes are held until accepted; fifo_full is a per-port level.
// Errors: bad slot header or early end-of-frame give a one-cycle blk_err.
module txframe_demux #(
    parameter int NPORT     = 4,
    parameter int BLK_BYTES = 128,
    parameter int HDR_BYTES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [7:0]         in_data,
    input  logic               in_valid,
    input  logic               in_sof,
    input  logic               in_eof,
    output logic               in_ready,
    input  logic [NPORT-1:0]   fifo_full,
    output logic [NPORT*8-1:0] out_data,
    output logic [NPORT-1:0]   out_valid,
    output logic               blk_err
);
    localparam int FRAME_BYTES = NPORT * BLK_BYTES;
    localparam int POS_W       = $clog2(FRAME_BYTES);
    localparam int OFF_W       = $clog2(BLK_BYTES);
    localparam int IDX_W       = $clog2(NPORT);
    localparam int MAX_PAY     = BLK_BYTES - HDR_BYTES;

    logic             accept;
    logic             live;
    logic [OFF_W-1:0] off;
    logic             short_end;
    logic             blk_ok;
    logic [IDX_W-1:0] blk_port;
    logic [7:0]       blk_len;
    logic             hdr_bad;

    assign accept   = in_valid && in_ready;
    assign out_data = {NPORT{in_data}};

    txdmx_frame_pos #(
        .FRAME_BYTES(FRAME_BYTES), .POS_W(POS_W), .OFF_W(OFF_W)
    ) i_pos (
        .clk(clk), .rst_n(rst_n), .accept(accept), .sof(in_sof), .eof(in_eof),
        .live(live), .off(off), .short_end(short_end)
    );

    txdmx_hdr_check #(
        .NPORT(NPORT), .MAX_PAY(MAX_PAY), .OFF_W(OFF_W), .IDX_W(IDX_W)
    ) i_hdr (
        .clk(clk), .rst_n(rst_n), .take(accept && live), .off(off), .din(in_data),
        .blk_ok(blk_ok), .blk_port(blk_port), .blk_len(blk_len), .hdr_bad(hdr_bad)
    );

    txdmx_route #(
        .NPORT(NPORT), .OFF_W(OFF_W), .IDX_W(IDX_W), .HDR_BYTES(HDR_BYTES)
    ) i_route (
        .live(live), .off(off), .blk_ok(blk_ok), .blk_port(blk_port), .blk_len(blk_len),
        .in_valid(in_valid), .fifo_full(fifo_full), .in_ready(in_ready), .out_valid(out_valid)
    );

    // Register the error pulse for the byte that revealed the fault.
    always_ff @(posedge clk) begin
        if (!rst_n) blk_err <= 1'b0;
        else        blk_err <= hdr_bad || short_end;
    end
endmodule

// File: rtl/txframe_demux_chk.sv
`timescale 1ns/1ps
// Port-level properties of the frame splitter, bound to every instance.
module txframe_demux_chk #(
    parameter int NPORT = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [NPORT-1:0] fifo_full,
    input logic [NPORT-1:0] out_valid,
    input logic             blk_err
);
    assert_one_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_valid));

    assert_no_write_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid & fifo_full) == '0);

    assert_stall_is_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> out_valid == '0);

    assert_err_follows_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
        blk_err |-> $past(in_valid && in_ready));

    assert_reset_clears_err_R11: assert property (@(posedge clk)
        !rst_n |=> !blk_err);
endmodule

bind txframe_demux txframe_demux_chk #(.NPORT(NPORT)) i_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .fifo_full(fifo_full), .out_valid(out_valid), .blk_err(blk_err)
);

// File: tb/test_txframe_demux.sv
`timescale 1ns/1ps
module test_txframe_demux;
    localparam int NP = 4, BLK = 128, FR = 512;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    in_data = '0;
    logic          in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [NP-1:0] fifo_full = '0;
    logic          in_ready;
    logic [NP*8-1:0] out_data;
    logic [NP-1:0] out_valid;
    logic          blk_err;

    int   checks = 0, errors = 0, err_seen = 0, err_exp = 0, stall_cycles = 0, cyc = 0;
    bit   bp_on = 1'b0, done = 1'b0;
    logic [7:0] expq[NP][$];
    logic [7:0] fr[FR];

    always #2.5 clk = ~clk;

    txframe_demux i_txframe_demux (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_sof(in_sof), .in_eof(in_eof), .in_ready(in_ready), .fifo_full(fifo_full),
        .out_data(out_data), .out_valid(out_valid), .blk_err(blk_err)
    );

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Fill one slot; the payload area is always filled completely.
    task automatic set_blk(int slot, int port, int tok, int len, int seed, int spare);
        fr[slot*BLK]   = 8'(port);
        fr[slot*BLK+1] = 8'(tok);
        fr[slot*BLK+2] = 8'(len);
        fr[slot*BLK+3] = 8'(spare);
        for (int k = 0; k < BLK-4; k++) fr[slot*BLK+4+k] = 8'(seed + k*7 + 1);
    endtask

    // Scoreboard push: first n payload bytes of a slot to the port in its header.
    task automatic push_exp(int slot, int n);
        int p;
        p = int'(fr[slot*BLK]);
        for (int k = 0; k < n; k++) expq[p].push_back(fr[slot*BLK+4+k]);
    endtask

    task automatic drive(int n, bit framed);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_data  = fr[i];
            in_valid = 1'b1;
            in_sof   = framed && (i == 0);
            in_eof   = framed && (i == n-1);
            forever begin
                #2;
                if (in_ready) break;
                @(negedge clk);
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    endtask

    task automatic settle(string req);
        repeat (4) @(negedge clk);
        chk(err_seen == err_exp, {req, " error pulses"}, err_seen, err_exp);
        for (int p = 0; p < NP; p++)
            chk(expq[p].size() == 0, {req, " bytes still owed"}, expq[p].size(), 0);
    endtask

    // Backpressure pattern, changed only on the falling edge.
    always @(negedge clk) begin
        cyc++;
        for (int p = 0; p < NP; p++) fifo_full[p] = bp_on && (((cyc + p*3) % 5) < 2);
    end

    // Monitor: compare forwarded bytes, count error pulses and stalls.
    always begin
        @(negedge clk);
        #2;
        if (rst_n) begin
            for (int p = 0; p < NP; p++) begin
                if (out_valid[p]) begin
                    if (expq[p].size() == 0) chk(1'b0, "R2 unexpected byte on port", p, -1);
                    else begin
                        logic [7:0] e;
                        e = expq[p].pop_front();
                        chk(out_data[p*8 +: 8] == e, "R2 R3 byte on port", int'(out_data[p*8 +: 8]), int'(e));
                    end
                end
            end
            if (blk_err) err_seen++;
            if (in_valid && !in_ready) begin
                stall_cycles++;
                chk(out_valid == '0, "R8 strobe during stall", int'(out_valid), 0);
            end
        end
    end

    initial begin
        // R11: reset state
        repeat (2) @(negedge clk);
        #2;
        chk(in_ready == 1'b1, "R11 ready in reset", in_ready, 1);
        chk(out_valid == '0, "R11 no strobe in reset", int'(out_valid), 0);
        chk(blk_err == 1'b0, "R11 no error in reset", blk_err, 0);
        @(negedge clk); rst_n = 1'b1;

        // R1 R2 R4 R7: slot order, spare byte ignored, zero and full counts
        set_blk(0, 0, 2, 10, 3, 0);
        set_blk(1, 1, 2, 0, 40, 0);
        set_blk(2, 2, 2, 124, 90, 8'h5A);
        set_blk(3, 3, 2, 1, 17, 8'hFF);
        push_exp(0, 10); push_exp(2, 124); push_exp(3, 1);
        drive(FR, 1'b1);
        settle("R1 R4 R7");

        // R3: routing by header port, not slot position
        set_blk(0, 3, 2, 20, 5, 0);
        set_blk(1, 0, 2, 5, 60, 0);
        set_blk(2, 2, 2, 0, 11, 0);
        set_blk(3, 1, 2, 60, 33, 0);
        push_exp(0, 20); push_exp(1, 5); push_exp(3, 60);
        drive(FR, 1'b1);
        settle("R3");

        // R5 R6 R7: bad token, bad port, oversize count
        set_blk(0, 1, 2, 7, 9, 0);
        set_blk(1, 2, 3, 9, 21, 0);
        set_blk(2, 4, 2, 5, 44, 0);
        set_blk(3, 0, 2, 125, 77, 0);
        push_exp(0, 7);
        err_exp += 3;
        drive(FR, 1'b1);
        settle("R5 R6 R7");

        // R8: backpressure on every port
        for (int s = 0; s < NP; s++) set_blk(s, s, 2, 124, s*13, 0);
        for (int s = 0; s < NP; s++) push_exp(s, 124);
        bp_on = 1'b1;
        drive(FR, 1'b1);
        bp_on = 1'b0;
        settle("R8");
        chk(stall_cycles > 0, "R8 input stalled", stall_cycles, 1);

        // R9: early end inside slot 1, then R10 stray bytes without a start
        set_blk(0, 2, 2, 50, 6, 0);
        set_blk(1, 1, 2, 100, 70, 0);
        push_exp(0, 50); push_exp(1, 68);
        err_exp += 1;
        drive(200, 1'b1);
        drive(8, 1'b0);
        settle("R9 R10");

        // R9: next frame handled normally after the abort
        set_blk(0, 1, 2, 3, 2, 0);
        set_blk(1, 0, 2, 124, 8, 0);
        set_blk(2, 3, 2, 2, 55, 0);
        set_blk(3, 2, 2, 0, 1, 0);
        push_exp(0, 3); push_exp(1, 124); push_exp(2, 2);
        drive(FR, 1'b1);
        settle("R9 recovery");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            chk(1'b0, "watchdog expired", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule